// File: doc/BRIEF.md
# Time Slot Channel Mapper

This block sits between a byte-wide TDM frame and a set of loop channels. Going out, software writes one control word per loop channel. The word says whether the channel carries a TDM time slot (and which one), a fixed idle byte, or bytes taken from an asynchronous byte port. Slot bytes are written into an internal slot store by index. A frame-start pulse then makes the block emit channels 0 to N-1 in order on a valid/ready channel stream. Coming back, bytes arriving per channel are steered by the same control words. Slot channels go to a slot-indexed output stream, asynchronous channels go to an asynchronous output stream, and everything else is dropped.

All three byte streams follow the usual valid/ready rules. A producer raising valid keeps data and index unchanged until the cycle in which ready is also high, and the transfer happens at that clock edge. The block's outgoing streams are registered. Each one holds a single byte, and that byte can be replaced in the same cycle it is taken. The asynchronous input is consumed only when an asynchronous channel is loaded into the outgoing channel register. It therefore sees back-pressure whenever the loop side stalls or no asynchronous channel is due. Configuration writes and the error flag are plain pins.

Top module: `tdm_chan_mapper`

## Requirements
- R1: Register write port.
  - Addresses 0 to 15 hold the per-channel words. Bits [5:0] are the slot index. Bits [7:6] are the mode: 00 slot, 01 blocked, 10 asynchronous, 11 reserved.
  - Address 16 holds the idle byte.
  - Address 17 is control. Bits [3:0] hold N-1, where N is the number of active channels. Bit [4] selects 64-slot mode (0 means 32-slot mode).
  - Reset values: idle byte 0xFF, N = 1, 32-slot mode, every channel word 0.
- R2: A frame-start pulse seen while no frame is in progress emits channels 0 to N-1 in ascending order, one per channel handshake. Channels N and above are never emitted. A pulse seen while a frame is in progress is ignored.
- R3: A slot-mode channel carries the byte most recently written to its slot index.
- R4: Blocked channels (mode 01) and reserved channels (mode 11) carry the idle byte.
- R5: An asynchronous channel carries the next pending asynchronous byte, in arrival order. If no byte is pending, it carries the idle byte and consumes nothing.
- R6: While the channel output is valid and not ready, its byte and index hold steady.
- R7: In 32-slot mode, slot-store writes to indices 32 to 63 are ignored.
- R8: The configuration error output is high when either of these holds for an active slot-mode channel:
  - its slot index is not strictly greater than the slot index of the previous active slot-mode channel;
  - its slot index is 32 or more while in 32-slot mode.
- R9: Loop bytes received on a slot-mode channel appear on the slot output, tagged with that channel's slot index. Bytes received on an asynchronous channel appear on the asynchronous output in arrival order. Bytes for blocked channels, reserved channels, or channels N and above are discarded.
- R10: The receive side stalls a loop byte only while its destination output holds a byte that is not being taken. Both outputs hold steady while stalled.
- R11: After reset all valid outputs are low, the asynchronous input is not ready, and the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_err | output | 1 | Slot ordering or range error in the active configuration |
| ts_we | input | 1 | Slot-store write strobe |
| ts_idx | input | 6 | Slot index for the write |
| ts_byte | input | 8 | Slot byte |
| frame_start | input | 1 | Starts emission of one frame of channels |
| ab_in_valid | input | 1 | Asynchronous byte offered |
| ab_in_ready | output | 1 | Asynchronous byte accepted this cycle |
| ab_in_data | input | 8 | Asynchronous byte |
| ch_out_valid | output | 1 | Channel byte available |
| ch_out_ready | input | 1 | Loop side takes the channel byte |
| ch_out_idx | output | 4 | Channel number of the byte |
| ch_out_byte | output | 8 | Channel byte |
| ch_in_valid | input | 1 | Received loop byte offered |
| ch_in_ready | output | 1 | Received loop byte accepted |
| ch_in_idx | input | 4 | Channel number of the received byte |
| ch_in_byte | input | 8 | Received loop byte |
| ts_out_valid | output | 1 | Demapped slot byte available |
| ts_out_ready | input | 1 | Slot byte taken |
| ts_out_idx | output | 6 | Slot index of the demapped byte |
| ts_out_byte | output | 8 | Demapped slot byte |
| ab_out_valid | output | 1 | Received asynchronous byte available |
| ab_out_ready | input | 1 | Asynchronous byte taken |
| ab_out_data | output | 8 | Received asynchronous byte |

## Verification
The hardest case to reach from the ports is an asynchronous channel that comes up in mid-frame with no byte pending. If this case is wrong, a stale byte is sent or a later byte is swallowed. It is also hard to catch the asynchronous load landing in the same cycle the loop side releases a stall. The stimulus reaches both cases by queueing fewer asynchronous bytes than a frame has asynchronous channels, while the loop-side ready follows a random pattern. A second frame then shows that the leftover byte and a newly queued byte land in the right channels. Out-of-range slot writes are covered by writing a slot in 32-slot mode and then reading it back through a channel after switching to 64-slot mode.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  typedef enum logic [1:0] {
    CM_PCM = 2'b00,
    CM_BLK = 2'b01,
    CM_ASY = 2'b10,
    CM_RSV = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/tcm_regs.sv
module tcm_regs #(
  parameter int NCH      = 16,
  parameter int SW       = 6,
  parameter int CW       = 4,
  parameter int AW       = 5,
  parameter int DW       = 8,
  parameter logic [7:0] IDLE_RST = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [DW-1:0]           cfg_wdata,
  output logic [NCH-1:0][SW-1:0]  ch_slot,
  output logic [NCH-1:0][1:0]     ch_mode,
  output logic [DW-1:0]           idle_byte,
  output logic [CW-1:0]           n_m1,
  output logic                    wide,
  output logic                    cfg_err
);
  import tcm_pkg::*;

  localparam logic [AW-1:0] IDLE_ADDR = AW'(NCH);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH + 1);

  // one control word per loop channel
  for (genvar g = 0; g < NCH; g++) begin : g_chreg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_slot[g] <= '0;
        ch_mode[g] <= 2'b00;
      end else if (cfg_we && cfg_addr == AW'(g)) begin
        ch_slot[g] <= cfg_wdata[SW-1:0];
        ch_mode[g] <= cfg_wdata[DW-1:DW-2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_byte <= IDLE_RST[DW-1:0];
      n_m1      <= '0;
      wide      <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == IDLE_ADDR) idle_byte <= cfg_wdata;
      if (cfg_addr == CTRL_ADDR) begin
        n_m1 <= cfg_wdata[CW-1:0];
        wide <= cfg_wdata[CW];
      end
    end
  end

  // ordering and range check over active slot-mode channels
  always_comb begin
    logic          seen;
    logic [SW-1:0] last;
    cfg_err = 1'b0;
    seen    = 1'b0;
    last    = '0;
    for (int i = 0; i < NCH; i++) begin
      if (CW'(i) <= n_m1 && ch_mode[i] == CM_PCM) begin
        if (!wide && ch_slot[i][SW-1]) cfg_err = 1'b1;
        if (seen && ch_slot[i] <= last) cfg_err = 1'b1;
        last = ch_slot[i];
        seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcm_slot_store.sv
module tcm_slot_store #(
  parameter int SLOTS = 64,
  parameter int SW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          wide,
  input  logic          ts_we,
  input  logic [SW-1:0] ts_idx,
  input  logic [DW-1:0] ts_byte,
  input  logic [SW-1:0] rd_idx,
  output logic [DW-1:0] rd_byte
);
  logic [DW-1:0] mem [SLOTS];
  logic          in_range;

  // upper half exists only in wide mode
  assign in_range = wide || !ts_idx[SW-1];

  always_ff @(posedge clk) begin
    if (ts_we && in_range) mem[ts_idx] <= ts_byte;
  end

  assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/tcm_tx_seq.sv
module tcm_tx_seq #(
  parameter int NCH = 16,
  parameter int SW  = 6,
  parameter int CW  = 4,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic [NCH-1:0][SW-1:0] ch_slot,
  input  logic [NCH-1:0][1:0]    ch_mode,
  input  logic [DW-1:0]          idle_byte,
  input  logic [CW-1:0]          n_m1,
  output logic [SW-1:0]          rd_idx,
  input  logic [DW-1:0]          rd_byte,
  input  logic                   ab_in_valid,
  output logic                   ab_in_ready,
  input  logic [DW-1:0]          ab_in_data,
  output logic                   ch_out_valid,
  input  logic                   ch_out_ready,
  output logic [CW-1:0]          ch_out_idx,
  output logic [DW-1:0]          ch_out_byte
);
  import tcm_pkg::*;

  logic          busy;
  logic [CW-1:0] ptr;
  logic          load;
  ch_mode_e      cur;
  logic [DW-1:0] nxt;

  assign load        = busy && (!ch_out_valid || ch_out_ready);
  assign cur         = ch_mode_e'(ch_mode[ptr]);
  assign rd_idx      = ch_slot[ptr];
  assign ab_in_ready = load && (cur == CM_ASY);

  always_comb begin
    case (cur)
      CM_PCM:  nxt = rd_byte;
      CM_ASY:  nxt = ab_in_valid ? ab_in_data : idle_byte;
      default: nxt = idle_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      ptr          <= '0;
      ch_out_valid <= 1'b0;
      ch_out_idx   <= '0;
      ch_out_byte  <= '0;
    end else if (load) begin
      ch_out_valid <= 1'b1;
      ch_out_idx   <= ptr;
      ch_out_byte  <= nxt;
      if (ptr == n_m1) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end else begin
      if (ch_out_ready) ch_out_valid <= 1'b0;
      if (!busy && frame_start) begin
        busy <= 1'b1;
        ptr  <= '0;
      end
    end
  end
endmodule

// File: rtl/tcm_rx_route.sv
module tcm_rx_route #(
  parameter int NCH = 16,
  parameter int SW  = 6,
  parameter int CW  = 4,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0][SW-1:0] ch_slot,
  input  logic [NCH-1:0][1:0]    ch_mode,
  input  logic [CW-1:0]          n_m1,
  input  logic                   ch_in_valid,
  output logic                   ch_in_ready,
  input  logic [CW-1:0]          ch_in_idx,
  input  logic [DW-1:0]          ch_in_byte,
  output logic                   ts_out_valid,
  input  logic                   ts_out_ready,
  output logic [SW-1:0]          ts_out_idx,
  output logic [DW-1:0]          ts_out_byte,
  output logic                   ab_out_valid,
  input  logic                   ab_out_ready,
  output logic [DW-1:0]          ab_out_data
);
  import tcm_pkg::*;

  logic     drop;
  ch_mode_e rmode;
  logic     ts_free, ab_free, take, to_ts, to_ab;

  assign drop    = ch_in_idx > n_m1;
  assign rmode   = ch_mode_e'(ch_mode[ch_in_idx]);
  assign ts_free = !ts_out_valid || ts_out_ready;
  assign ab_free = !ab_out_valid || ab_out_ready;
  assign to_ts   = !drop && rmode == CM_PCM;
  assign to_ab   = !drop && rmode == CM_ASY;

  always_comb begin
    if (to_ts)      ch_in_ready = ts_free;
    else if (to_ab) ch_in_ready = ab_free;
    else            ch_in_ready = 1'b1;
  end

  assign take = ch_in_valid && ch_in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_out_valid <= 1'b0;
      ts_out_idx   <= '0;
      ts_out_byte  <= '0;
      ab_out_valid <= 1'b0;
      ab_out_data  <= '0;
    end else begin
      if (ts_out_ready) ts_out_valid <= 1'b0;
      if (ab_out_ready) ab_out_valid <= 1'b0;
      if (take && to_ts) begin
        ts_out_valid <= 1'b1;
        ts_out_idx   <= ch_slot[ch_in_idx];
        ts_out_byte  <= ch_in_byte;
      end
      if (take && to_ab) begin
        ab_out_valid <= 1'b1;
        ab_out_data  <= ch_in_byte;
      end
    end
  end
endmodule

// File: rtl/tdm_chan_mapper.sv
module tdm_chan_mapper #(
  parameter int NCH   = 16,
  parameter int SLOTS = 64,
  parameter int DW    = 8,
  parameter logic [7:0] IDLE_RST = 8'hFF,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(NCH),
  localparam int AW = $clog2(NCH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          cfg_err,
  input  logic          ts_we,
  input  logic [SW-1:0] ts_idx,
  input  logic [DW-1:0] ts_byte,
  input  logic          frame_start,
  input  logic          ab_in_valid,
  output logic          ab_in_ready,
  input  logic [DW-1:0] ab_in_data,
  output logic          ch_out_valid,
  input  logic          ch_out_ready,
  output logic [CW-1:0] ch_out_idx,
  output logic [DW-1:0] ch_out_byte,
  input  logic          ch_in_valid,
  output logic          ch_in_ready,
  input  logic [CW-1:0] ch_in_idx,
  input  logic [DW-1:0] ch_in_byte,
  output logic          ts_out_valid,
  input  logic          ts_out_ready,
  output logic [SW-1:0] ts_out_idx,
  output logic [DW-1:0] ts_out_byte,
  output logic          ab_out_valid,
  input  logic          ab_out_ready,
  output logic [DW-1:0] ab_out_data
);
  logic [NCH-1:0][SW-1:0] ch_slot;
  logic [NCH-1:0][1:0]    ch_mode;
  logic [DW-1:0]          idle_byte;
  logic [CW-1:0]          n_m1;
  logic                   wide;
  logic [SW-1:0]          rd_idx;
  logic [DW-1:0]          rd_byte;

  tcm_regs #(.NCH(NCH), .SW(SW), .CW(CW), .AW(AW), .DW(DW), .IDLE_RST(IDLE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ch_slot(ch_slot), .ch_mode(ch_mode), .idle_byte(idle_byte), .n_m1(n_m1),
    .wide(wide), .cfg_err(cfg_err)
  );

  tcm_slot_store #(.SLOTS(SLOTS), .SW(SW), .DW(DW)) u_store (
    .clk(clk), .wide(wide), .ts_we(ts_we), .ts_idx(ts_idx), .ts_byte(ts_byte),
    .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  tcm_tx_seq #(.NCH(NCH), .SW(SW), .CW(CW), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_slot(ch_slot),
    .ch_mode(ch_mode), .idle_byte(idle_byte), .n_m1(n_m1), .rd_idx(rd_idx),
    .rd_byte(rd_byte), .ab_in_valid(ab_in_valid), .ab_in_ready(ab_in_ready),
    .ab_in_data(ab_in_data), .ch_out_valid(ch_out_valid), .ch_out_ready(ch_out_ready),
    .ch_out_idx(ch_out_idx), .ch_out_byte(ch_out_byte)
  );

  tcm_rx_route #(.NCH(NCH), .SW(SW), .CW(CW), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .ch_slot(ch_slot), .ch_mode(ch_mode), .n_m1(n_m1),
    .ch_in_valid(ch_in_valid), .ch_in_ready(ch_in_ready), .ch_in_idx(ch_in_idx),
    .ch_in_byte(ch_in_byte), .ts_out_valid(ts_out_valid), .ts_out_ready(ts_out_ready),
    .ts_out_idx(ts_out_idx), .ts_out_byte(ts_out_byte), .ab_out_valid(ab_out_valid),
    .ab_out_ready(ab_out_ready), .ab_out_data(ab_out_data)
  );
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
  parameter int DW = 8,
  parameter int CW = 4,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ch_out_valid,
  input logic          ch_out_ready,
  input logic [CW-1:0] ch_out_idx,
  input logic [DW-1:0] ch_out_byte,
  input logic          ab_in_valid,
  input logic          ab_in_ready,
  input logic [DW-1:0] ab_in_data,
  input logic          ts_out_valid,
  input logic          ts_out_ready,
  input logic [SW-1:0] ts_out_idx,
  input logic [DW-1:0] ts_out_byte,
  input logic          ab_out_valid,
  input logic          ab_out_ready,
  input logic [DW-1:0] ab_out_data,
  input logic [CW-1:0] n_m1
);
  assert_chout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ch_out_valid && !ch_out_ready |=> ch_out_valid && $stable(ch_out_idx) && $stable(ch_out_byte));

  // channel numbers stay below N (configuration is not changed mid-frame)
  assert_chan_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ch_out_valid |-> ch_out_idx <= n_m1);

  assert_async_carried_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ab_in_valid && ab_in_ready |=> ch_out_valid && ch_out_byte == $past(ab_in_data));

  assert_async_slot_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ab_in_ready |-> !ch_out_valid || ch_out_ready);

  assert_tsout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ts_out_valid && !ts_out_ready |=> ts_out_valid && $stable(ts_out_idx) && $stable(ts_out_byte));

  assert_about_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ab_out_valid && !ab_out_ready |=> ab_out_valid && $stable(ab_out_data));
endmodule

bind tdm_chan_mapper tcm_checker #(.DW(DW), .CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ch_out_valid(ch_out_valid), .ch_out_ready(ch_out_ready),
  .ch_out_idx(ch_out_idx), .ch_out_byte(ch_out_byte),
  .ab_in_valid(ab_in_valid), .ab_in_ready(ab_in_ready), .ab_in_data(ab_in_data),
  .ts_out_valid(ts_out_valid), .ts_out_ready(ts_out_ready),
  .ts_out_idx(ts_out_idx), .ts_out_byte(ts_out_byte),
  .ab_out_valid(ab_out_valid), .ab_out_ready(ab_out_ready), .ab_out_data(ab_out_data),
  .n_m1(n_m1)
);

// File: tb/tb_tdm_chan_mapper.sv
`timescale 1ns/1ps
module tb_tdm_chan_mapper;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       cfg_err;
  logic       ts_we = 1'b0;
  logic [5:0] ts_idx = '0;
  logic [7:0] ts_byte = '0;
  logic       frame_start = 1'b0;
  logic       ab_in_valid = 1'b0;
  logic       ab_in_ready;
  logic [7:0] ab_in_data = '0;
  logic       ch_out_valid;
  logic       ch_out_ready = 1'b1;
  logic [3:0] ch_out_idx;
  logic [7:0] ch_out_byte;
  logic       ch_in_valid = 1'b0;
  logic       ch_in_ready;
  logic [3:0] ch_in_idx = '0;
  logic [7:0] ch_in_byte = '0;
  logic       ts_out_valid;
  logic       ts_out_ready = 1'b1;
  logic [5:0] ts_out_idx;
  logic [7:0] ts_out_byte;
  logic       ab_out_valid;
  logic       ab_out_ready = 1'b1;
  logic [7:0] ab_out_data;

  tdm_chan_mapper dut (.*);

  int total = 0, bad = 0;
  bit done = 0, bp = 0;
  int m_slot[16], m_mode[16], m_idle = 255, m_nm1 = 0, m_wide = 0;
  int mem[64];
  logic [7:0] aq[$];
  int exp_tx[$], exp_ts[$], exp_ab[$];

  // monitor state
  bit tx_st = 0, ts_st = 0, ab_st = 0;
  int s_idx, s_byte, s_tsi, s_tsb, s_abd, e;
  string rq;

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit model_err();
    bit er = 0, seen = 0;
    int last = 0;
    for (int i = 0; i <= m_nm1; i++)
      if (m_mode[i] == 0) begin
        if (!m_wide && m_slot[i] >= 32) er = 1;
        if (seen && m_slot[i] <= last) er = 1;
        last = m_slot[i];
        seen = 1;
      end
    return er;
  endfunction

  // kind: 0 slot low, 1 idle, 2 async, 3 slot upper half
  function automatic void build_frame();
    int k = 0;
    for (int i = 0; i <= m_nm1; i++) begin
      int d, kind;
      if (m_mode[i] == 0) begin
        d = mem[m_slot[i]]; kind = (m_slot[i] >= 32) ? 3 : 0;
      end else if (m_mode[i] == 2) begin
        kind = 2;
        if (k < aq.size()) begin d = aq[k]; k++; end
        else d = m_idle;
      end else begin
        d = m_idle; kind = 1;
      end
      exp_tx.push_back((kind << 16) | (i << 8) | d);
    end
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk); cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
    @(negedge clk); cfg_we = 0;
    if (a < 16) begin m_slot[a] = d & 63; m_mode[a] = (d >> 6) & 3; end
    else if (a == 16) m_idle = d & 255;
    else begin m_nm1 = d & 15; m_wide = (d >> 4) & 1; end
  endtask

  task automatic set_ch(int i, int mode, int slot);
    wr(i, (mode << 6) | slot);
  endtask

  task automatic ts_wr(int i, int d);
    @(negedge clk); ts_we = 1; ts_idx = 6'(i); ts_byte = 8'(d);
    @(negedge clk); ts_we = 0;
    if (m_wide || i < 32) mem[i] = d & 255;
  endtask

  task automatic drain();
    int g = 0;
    while ((exp_tx.size() || exp_ts.size() || exp_ab.size()) && g < 5000) begin
      @(negedge clk); g++;
    end
    repeat (6) @(negedge clk);
    chk(exp_tx.size() == 0, "R2 channels left unsent", exp_tx.size(), 0);
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1; build_frame();
    @(negedge clk); frame_start = 0;
    drain();
  endtask

  task automatic rx_send(int ch, int d);
    if (ch <= m_nm1 && m_mode[ch] == 0) exp_ts.push_back((m_slot[ch] << 8) | d);
    else if (ch <= m_nm1 && m_mode[ch] == 2) exp_ab.push_back(d);
    @(negedge clk); ch_in_valid = 1; ch_in_idx = 4'(ch); ch_in_byte = 8'(d);
    #1;
    while (!ch_in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  always @(negedge clk) begin
    ch_out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
    ts_out_ready = bp ? (($urandom % 2) != 0) : 1'b1;
    ab_out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
    ab_in_valid  = aq.size() > 0;
    ab_in_data   = (aq.size() > 0) ? aq[0] : 8'h00;
    #1;
    if (rst_n) begin
      if (tx_st) chk(ch_out_valid && ch_out_idx == s_idx && ch_out_byte == s_byte,
                     "R6 channel output changed while stalled", ch_out_byte, s_byte);
      tx_st = ch_out_valid && !ch_out_ready; s_idx = ch_out_idx; s_byte = ch_out_byte;
      if (ts_st) chk(ts_out_valid && ts_out_idx == s_tsi && ts_out_byte == s_tsb,
                     "R10 slot output changed while stalled", ts_out_byte, s_tsb);
      ts_st = ts_out_valid && !ts_out_ready; s_tsi = ts_out_idx; s_tsb = ts_out_byte;
      if (ab_st) chk(ab_out_valid && ab_out_data == s_abd,
                     "R10 async output changed while stalled", ab_out_data, s_abd);
      ab_st = ab_out_valid && !ab_out_ready; s_abd = ab_out_data;

      if (ch_out_valid && ch_out_ready) begin
        if (exp_tx.size() == 0) chk(0, "R2 unexpected channel", ch_out_idx, -1);
        else begin
          e = exp_tx.pop_front();
          case ((e >> 16) & 3)
            0: rq = "R3 slot channel";
            1: rq = "R4 idle channel";
            2: rq = "R5 async channel";
            default: rq = "R7 upper slot channel";
          endcase
          chk(ch_out_idx == ((e >> 8) & 15), "R2 channel order", ch_out_idx, (e >> 8) & 15);
          chk(ch_out_byte == (e & 255), rq, ch_out_byte, e & 255);
        end
      end
      if (ab_in_valid && ab_in_ready) void'(aq.pop_front());
      if (ts_out_valid && ts_out_ready) begin
        if (exp_ts.size() == 0) chk(0, "R9 unexpected slot byte", ts_out_byte, -1);
        else begin
          e = exp_ts.pop_front();
          chk({ts_out_idx, ts_out_byte} == 14'(e), "R9 slot demap", {ts_out_idx, ts_out_byte}, e);
        end
      end
      if (ab_out_valid && ab_out_ready) begin
        if (exp_ab.size() == 0) chk(0, "R9 unexpected async byte", ab_out_data, -1);
        else begin
          e = exp_ab.pop_front();
          chk(ab_out_data == e, "R9 async demap order", ab_out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_slot[i] = 0; m_mode[i] = 0; end
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!ch_out_valid && !ts_out_valid && !ab_out_valid, "R11 valids low after reset",
        {ch_out_valid, ts_out_valid, ab_out_valid}, 0);
    chk(!ab_in_ready && !cfg_err, "R11 ready and error low after reset", {ab_in_ready, cfg_err}, 0);

    // R1 defaults: N=1, 32-slot mode, idle 0xFF
    for (int i = 0; i < 32; i++) ts_wr(i, i ^ 8'hA5);
    frame();
    set_ch(0, 1, 0);
    frame();
    chk(cfg_err == 0, "R8 default config has no error", cfg_err, 0);

    // main mixed configuration, 64-slot mode, N=8
    wr(17, 16 | 7);
    for (int i = 0; i < 64; i++) ts_wr(i, (i * 7 + 3) & 255);
    wr(16, 8'h5A);
    set_ch(0, 0, 3);  set_ch(1, 1, 0);  set_ch(2, 0, 10); set_ch(3, 2, 0);
    set_ch(4, 0, 40); set_ch(5, 3, 0);  set_ch(6, 2, 0);  set_ch(7, 0, 63);
    chk(cfg_err == model_err(), "R8 ascending config", cfg_err, model_err());
    aq.push_back(8'h11); aq.push_back(8'h22);
    frame();
    bp = 1;
    aq.push_back(8'h33); aq.push_back(8'h44); aq.push_back(8'h55);
    frame();
    chk(aq.size() == 1 && aq[0] == 8'h55, "R5 leftover byte kept in order", aq.size(), 1);
    frame();
    chk(aq.size() == 0, "R5 starved channel consumes nothing", aq.size(), 0);
    aq.push_back(8'h77);
    frame();

    // R2: pulse held over two edges, second one lands while busy
    @(negedge clk); frame_start = 1; build_frame();
    @(negedge clk);
    @(negedge clk); frame_start = 0;
    drain();

    // R8 and R7
    wr(17, 7);
    chk(cfg_err == 1 && model_err() == 1, "R8 upper slot in 32-slot mode", cfg_err, 1);
    ts_wr(40, 8'hEE);
    wr(17, 16 | 7);
    chk(cfg_err == 0, "R8 back in 64-slot mode", cfg_err, 0);
    frame();
    set_ch(2, 0, 3);
    chk(cfg_err == 1, "R8 equal slots", cfg_err, 1);
    set_ch(2, 0, 2);
    chk(cfg_err == 1, "R8 descending slots", cfg_err, 1);
    wr(17, 16 | 1);
    chk(cfg_err == 0, "R8 inactive channels ignored", cfg_err, 0);
    frame();
    wr(17, 16 | 7);
    chk(cfg_err == 1, "R8 error returns with N=8", cfg_err, 1);
    set_ch(2, 0, 10);
    chk(cfg_err == 0, "R8 repaired", cfg_err, 0);

    // full 16-channel frame
    for (int i = 8; i < 16; i++) set_ch(i, i % 4, (i * 4) & 63);
    wr(17, 16 | 15);
    aq.push_back(8'hC1); aq.push_back(8'hC2); aq.push_back(8'hC3);
    frame();
    void'(aq.size());

    // receive direction with N=8
    aq.delete();
    wr(17, 16 | 7);
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 10; c++) rx_send(c, (r * 16 + c * 5 + 1) & 255);
    @(negedge clk); ch_in_valid = 0;
    drain();
    chk(exp_ts.size() == 0 && exp_ab.size() == 0, "R9 all routed bytes delivered",
        exp_ts.size() + exp_ab.size(), 0);

    bp = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule